// File: doc/BRIEF.md
# Nonvolatile Setting Store/Restore Sequencer

This block sequences data movement between an 8-bit volatile wiper register and an 8-bit nonvolatile setting cell. The cell is modelled as a plain register whose busy time is set by parameters. At power-on the wiper is forced to midscale. An automatic recall then overwrites it with the cell contents. After that, a command decoder can ask the block to copy the wiper into the cell (store), to copy the cell back into the wiper (recall), or to leave the powered read state (NOP).

Store, recall and post-power-on lockout durations are parameters counted in clock cycles, so a bench can use short windows. The `busy` output covers every store or recall. The `lp_idle` output is high only in the low-power idle state. A recall issued by command leaves the block in a read-active state, and only a NOP request ends it. The `factory_prog` strobe models the factory preload of the cell to midscale. The cell itself is never cleared by `rst_n`, so its contents survive power cycles. `rst_n` is asserted asynchronously and must be deasserted synchronously to `clk`.

Top module: `nvm_wiper_seq`

## Requirements
- R1: While `rst_n` is low, and after its release until the power-on recall ends, `wiper` reads midscale (0x80, only the MSB set) and `busy` is high.
- R2: The power-on recall keeps `busy` high for exactly T_RESTORE rising edges after reset release and then loads `wiper` from the cell. After `factory_prog`, the cell holds 0x80.
- R3: An accepted store keeps `busy` high for exactly T_STORE edges. It writes into the cell the `wiper` value held at the accepting edge, and that value survives later resets.
- R4: Store requests are ignored until the lockout ends. The first rising edge after reset release that can accept a store is edge number T_LOCKOUT+1.
- R5: Store and recall requests that arrive while `busy` is high are ignored.
- R6: A direct write (`wr_en`) updates `wiper` at the next edge in every state except the two recall states, where it is ignored. A write during a store does not change the value being stored.
- R7: A recall command keeps `busy` high for T_RESTORE edges and loads `wiper` from the cell. The block then stays read-active (`busy` low, `lp_idle` low) until a NOP, a store or a recall is accepted.
- R8: A NOP in the read-active state sets `lp_idle` at the next edge. A NOP in idle changes nothing.
- R9: `lp_idle` is high only when no transfer is running and the read-active state is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| factory_prog | input | 1 | Loads the factory value (midscale) into the cell |
| store_req | input | 1 | Strobe: copy wiper into cell |
| restore_req | input | 1 | Strobe: copy cell into wiper |
| nop_req | input | 1 | Strobe: leave read-active state |
| wr_en | input | 1 | Direct wiper write enable |
| wr_data | input | DATA_W | Direct wiper write value |
| wiper | output | DATA_W | Current wiper setting |
| busy | output | 1 | Store or recall in progress |
| lp_idle | output | 1 | Low-power idle state |

## Verification
Assertions check the following on every cycle: each timer steps down by one and sticks at zero; a store only begins once the lockout has expired; a running store is not interrupted; the wiper holds still through a store unless a direct write arrives; and the read-active state persists while no request arrives. Other properties only the bench scenarios can show. These are the exact busy lengths, the lockout boundary edge, the preservation of the latched store value against a mid-store write, and retention of a sweep of codes (including 0x00, 0xFF and 0x80) across repeated power cycles.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [2:0] {
    SQ_BOOT   = 3'd0,
    SQ_IDLE   = 3'd1,
    SQ_STORE  = 3'd2,
    SQ_RECALL = 3'd3,
    SQ_HOLD   = 3'd4
  } seq_state_e;

  function automatic int unsigned cnt_width(input int unsigned maxval);
    if (maxval < 2) return 1;
    return $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int unsigned   W       = 4,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign zero = (cnt_q == '0);
  assign cnt  = cnt_q;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (dec && !zero) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R3 / R2: windows shrink by exactly one per enabled cycle
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && !zero) |=> (cnt == $past(cnt) - 1'b1));

  // R4: an expired window stays expired until reloaded
  a_r4_floor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/nvseq_cell.sv
module nvseq_cell #(
  parameter int unsigned      W       = 8,
  parameter logic [W-1:0]     FACTORY = 8'h80
) (
  input  logic         clk,
  input  logic         prog,
  input  logic         commit,
  input  logic [W-1:0] commit_data,
  output logic [W-1:0] value
);

  // Nonvolatile model: deliberately outside the power-on reset domain.
  logic [W-1:0] mem_q;
  logic [W-1:0] mem_d;
  logic         mem_en;

  always_comb begin
    mem_en = prog | commit;
    mem_d  = prog ? FACTORY : commit_data;
  end

  always_ff @(posedge clk) begin
    if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  assign value = mem_q;

endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int unsigned  W         = 8,
  parameter int unsigned  TW        = 4,
  parameter int unsigned  T_STORE   = 8,
  parameter int unsigned  T_RESTORE = 4,
  parameter logic [W-1:0] MID       = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store_req,
  input  logic          restore_req,
  input  logic          nop_req,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          tmr_zero,
  input  logic          unlocked,
  input  logic [W-1:0]  cell_q,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_load_val,
  output logic          tmr_dec,
  output logic          cell_commit,
  output logic [W-1:0]  cell_data,
  output logic [W-1:0]  wiper,
  output logic          busy,
  output logic          lp_idle
);

  localparam logic [TW-1:0] STORE_LD  = TW'(T_STORE - 1);
  localparam logic [TW-1:0] RECALL_LD = TW'(T_RESTORE - 1);

  seq_state_e   state_q, state_d;
  logic [W-1:0] wiper_q, wiper_d;
  logic         wiper_en;
  logic [W-1:0] snap_q;
  logic         snap_en;
  logic         recalling;

  assign recalling = (state_q == SQ_BOOT) || (state_q == SQ_RECALL);

  always_comb begin
    state_d      = state_q;
    tmr_load     = 1'b0;
    tmr_load_val = '0;
    tmr_dec      = 1'b0;
    cell_commit  = 1'b0;
    snap_en      = 1'b0;
    wiper_en     = 1'b0;
    wiper_d      = wiper_q;

    if (wr_en && !recalling) begin
      wiper_en = 1'b1;
      wiper_d  = wr_data;
    end

    unique case (state_q)
      SQ_IDLE, SQ_HOLD: begin
        if (store_req && unlocked) begin
          state_d      = SQ_STORE;
          tmr_load     = 1'b1;
          tmr_load_val = STORE_LD;
          snap_en      = 1'b1;
        end else if (restore_req) begin
          state_d      = SQ_RECALL;
          tmr_load     = 1'b1;
          tmr_load_val = RECALL_LD;
        end else if (nop_req) begin
          state_d = SQ_IDLE;
        end
      end
      SQ_STORE: begin
        tmr_dec = 1'b1;
        if (tmr_zero) begin
          cell_commit = 1'b1;
          state_d     = SQ_IDLE;
        end
      end
      SQ_BOOT, SQ_RECALL: begin
        tmr_dec = 1'b1;
        if (tmr_zero) begin
          wiper_en = 1'b1;
          wiper_d  = cell_q;
          state_d  = (state_q == SQ_BOOT) ? SQ_IDLE : SQ_HOLD;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_BOOT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= MID;
    end else if (wiper_en) begin
      wiper_q <= wiper_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_en) begin
      snap_q <= wiper_q;
    end
  end

  assign cell_data = snap_q;
  assign wiper     = wiper_q;
  assign busy      = (state_q == SQ_STORE) || recalling;
  assign lp_idle   = (state_q == SQ_IDLE);

  // R4: a store only begins once the lockout timer has run out
  a_r4_store_after_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_STORE && $past(state_q) != SQ_STORE) |-> $past(unlocked));

  // R5: a running store is not cut short by any request
  a_r5_store_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_STORE && !tmr_zero) |=> (state_q == SQ_STORE));

  // R6: the wiper moves during a store only through a direct write
  a_r6_wiper_still_in_store: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_STORE && $past(state_q) == SQ_STORE && !$past(wr_en))
      |-> $stable(wiper_q));

  // R7: the read-active state persists while no request arrives
  a_r7_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_HOLD && !store_req && !restore_req && !nop_req)
      |=> (state_q == SQ_HOLD));

endmodule

// File: rtl/nvm_wiper_seq.sv
module nvm_wiper_seq
  import nvseq_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned T_RESTORE = 30000,
  parameter int unsigned T_STORE   = 2600000,
  parameter int unsigned T_LOCKOUT = 54000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              factory_prog,
  input  logic              store_req,
  input  logic              restore_req,
  input  logic              nop_req,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] wiper,
  output logic              busy,
  output logic              lp_idle
);

  localparam logic [DATA_W-1:0] MIDSCALE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int unsigned SEQ_MAX = (T_STORE > T_RESTORE) ? T_STORE : T_RESTORE;
  localparam int unsigned SEQ_W   = cnt_width(SEQ_MAX);
  localparam int unsigned LOCK_W  = cnt_width(T_LOCKOUT);

  logic              tmr_load;
  logic [SEQ_W-1:0]  tmr_load_val;
  logic              tmr_dec;
  logic              tmr_zero;
  logic [SEQ_W-1:0]  tmr_cnt;
  logic              lock_done;
  logic [LOCK_W-1:0] lock_cnt;
  logic              cell_commit;
  logic [DATA_W-1:0] cell_data;
  logic [DATA_W-1:0] cell_q;

  nvseq_timer #(
    .W       (SEQ_W),
    .RST_VAL (SEQ_W'(T_RESTORE - 1))
  ) u_seq_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .dec      (tmr_dec),
    .cnt      (tmr_cnt),
    .zero     (tmr_zero)
  );

  nvseq_timer #(
    .W       (LOCK_W),
    .RST_VAL (LOCK_W'(T_LOCKOUT))
  ) u_lock_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (1'b0),
    .load_val ('0),
    .dec      (1'b1),
    .cnt      (lock_cnt),
    .zero     (lock_done)
  );

  nvseq_cell #(
    .W       (DATA_W),
    .FACTORY (MIDSCALE)
  ) u_cell (
    .clk         (clk),
    .prog        (factory_prog),
    .commit      (cell_commit),
    .commit_data (cell_data),
    .value       (cell_q)
  );

  nvseq_ctrl #(
    .W         (DATA_W),
    .TW        (SEQ_W),
    .T_STORE   (T_STORE),
    .T_RESTORE (T_RESTORE),
    .MID       (MIDSCALE)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .store_req    (store_req),
    .restore_req  (restore_req),
    .nop_req      (nop_req),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .tmr_zero     (tmr_zero),
    .unlocked     (lock_done),
    .cell_q       (cell_q),
    .tmr_load     (tmr_load),
    .tmr_load_val (tmr_load_val),
    .tmr_dec      (tmr_dec),
    .cell_commit  (cell_commit),
    .cell_data    (cell_data),
    .wiper        (wiper),
    .busy         (busy),
    .lp_idle      (lp_idle)
  );

  // R3: the cell is only written when the transfer window has closed
  a_r3_commit_closes_window: assert property (@(posedge clk) disable iff (!rst_n)
    cell_commit |-> (busy && tmr_cnt == '0));

  // R9: the idle flag never overlaps a transfer
  a_r9_idle_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    lp_idle |-> !busy);

endmodule

// File: tb/tb_nvm_wiper_seq.sv
`timescale 1ns/1ps
module tb_nvm_wiper_seq;

  localparam int DW  = 8;
  localparam int TR  = 6;
  localparam int TS  = 20;
  localparam int TL  = 30;
  localparam int MID = 8'h80;

  logic          clk;
  logic          rst_n;
  logic          factory_prog;
  logic          store_req;
  logic          restore_req;
  logic          nop_req;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] wiper;
  logic          busy;
  logic          lp_idle;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;

  nvm_wiper_seq #(
    .DATA_W    (DW),
    .T_RESTORE (TR),
    .T_STORE   (TS),
    .T_LOCKOUT (TL)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .factory_prog (factory_prog),
    .store_req    (store_req),
    .restore_req  (restore_req),
    .nop_req      (nop_req),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .wiper        (wiper),
    .busy         (busy),
    .lp_idle      (lp_idle)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic boot(input bit poke, output int n);
    rst_n = 1'b1;
    n = 0;
    while (busy && n < 100) begin
      if (poke && n == 1) begin
        wr_en = 1'b1; wr_data = 8'h11; restore_req = 1'b1;
      end else begin
        wr_en = 1'b0; restore_req = 1'b0;
      end
      step(1);
      n++;
      if (busy) chk("R1 wiper during boot", int'(wiper), MID);
    end
    wr_en = 1'b0;
    restore_req = 1'b0;
  endtask

  task automatic run_busy(output int n);
    n = 0;
    while (busy && n < 200) begin
      step(1);
      n++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int stored;
    logic [7:0] vals [8];
    vals = '{8'h00, 8'hFF, 8'h01, 8'h7F, 8'h80, 8'h55, 8'hAA, 8'hC3};

    rst_n = 1'b0; factory_prog = 1'b0; store_req = 1'b0; restore_req = 1'b0;
    nop_req = 1'b0; wr_en = 1'b0; wr_data = '0;
    step(2);
    factory_prog = 1'b1;
    step(1);
    factory_prog = 1'b0;
    step(1);
    chk("R1 wiper in reset", int'(wiper), MID);
    chk("R1 busy in reset", int'(busy), 1);
    chk("R9 idle in reset", int'(lp_idle), 0);

    // first power-up, with a write and a recall poked into the window (R5, R6)
    boot(1'b1, n);
    chk("R2 boot length", n, TR);
    chk("R5 boot not extended", n, TR);
    chk("R2 factory midscale", int'(wiper), MID);
    chk("R9 idle after boot", int'(lp_idle), 1);
    chk("R6 write ignored in recall", int'(wiper), MID);

    while (cyc < 10) step(1);
    wr_en = 1'b1; wr_data = 8'h3C;
    step(1);
    wr_en = 1'b0;
    chk("R6 direct write", int'(wiper), 8'h3C);

    store_req = 1'b1;
    step(1);
    store_req = 1'b0;
    chk("R4 early store ignored", int'(busy), 0);
    chk("R4 idle kept", int'(lp_idle), 1);

    while (cyc < TL - 1) step(1);
    store_req = 1'b1;
    step(1);
    store_req = 1'b0;
    chk("R4 edge TL ignored", int'(busy), 0);
    store_req = 1'b1;
    step(1);
    store_req = 1'b0;
    chk("R4 edge TL+1 accepted", int'(busy), 1);

    n = 0;
    while (busy && n < 200) begin
      if (n == 4) begin
        wr_en = 1'b1; wr_data = 8'hA5; restore_req = 1'b1; store_req = 1'b1;
      end else begin
        wr_en = 1'b0; restore_req = 1'b0; store_req = 1'b0;
      end
      step(1);
      n++;
      if (n == 5) chk("R6 write during store", int'(wiper), 8'hA5);
    end
    wr_en = 1'b0; restore_req = 1'b0; store_req = 1'b0;
    chk("R3 store length", n, TS);
    chk("R5 store not restarted", n, TS);
    chk("R6 wiper after store", int'(wiper), 8'hA5);
    chk("R9 idle after store", int'(lp_idle), 1);

    restore_req = 1'b1;
    step(1);
    restore_req = 1'b0;
    chk("R7 recall busy", int'(busy), 1);
    run_busy(n);
    chk("R7 recall length", n, TR);
    chk("R3 latched value stored", int'(wiper), 8'h3C);
    chk("R7 read-active busy", int'(busy), 0);
    chk("R7 read-active idle flag", int'(lp_idle), 0);
    step(8);
    chk("R7 read-active persists", int'(lp_idle), 0);

    nop_req = 1'b1;
    step(1);
    nop_req = 1'b0;
    chk("R8 nop to idle", int'(lp_idle), 1);
    nop_req = 1'b1;
    step(1);
    nop_req = 1'b0;
    chk("R8 nop in idle flag", int'(lp_idle), 1);
    chk("R8 nop in idle wiper", int'(wiper), 8'h3C);
    chk("R8 nop in idle busy", int'(busy), 0);

    // retention sweep across power cycles (R3)
    stored = 8'h3C;
    for (int i = 0; i < 8; i++) begin
      rst_n = 1'b0;
      step(2);
      chk("R1 wiper in reset", int'(wiper), MID);
      boot(1'b0, n);
      chk("R2 boot length", n, TR);
      chk("R3 retained across reset", int'(wiper), stored);
      step(TL);
      wr_en = 1'b1; wr_data = vals[i];
      step(1);
      wr_en = 1'b0;
      store_req = 1'b1;
      step(1);
      store_req = 1'b0;
      run_busy(n);
      chk("R3 store length", n, TS);
      stored = int'(vals[i]);
    end
    rst_n = 1'b0;
    step(2);
    boot(1'b0, n);
    chk("R3 retained across reset", int'(wiper), stored);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule